// File: doc/BRIEF.md
# Wrapping Bitfield Execution Unit

This unit performs bitfield operations for a 64-bit processor pipeline. A field is named by two 6-bit bit indices, a low (start) index and a high (end) index. When start exceeds end, the field wraps past the top of the word and continues from bit zero. Four operations act on such a field: zero-extended extract, sign-extended extract, insert into an old destination value, and a mask-merge that selects bitwise between the old destination and source A under a rotated field mask.

The issuing stage presents the operands, the field indices, a 2-bit operation code, an enable bit and a valid strobe in one cycle. The result is registered and appears one clock later together with a result-valid flag. A valid strobe with the enable bit low is rejected through an illegal-operation flag. Operand fetch, instruction decode and exception handling sit outside the unit.

Top module: `bitfield_unit`

## Requirements
- R1: When start <= end, the field covers bits start..end inclusive and is end-start+1 bits long.
- R2: When start > end, the field covers bits start..63 and then 0..end, with length (64-start)+(end+1). Bits taken from the top of the word form the low part of the field and bits 0..end sit above them.
- R3: Operation code 2'b00 (zero-extended extract) returns the field right-aligned in the result with every bit above the field length cleared.
- R4: Operation code 2'b01 (sign-extended extract) returns the same right-aligned field, with every bit above it equal to source A bit [end].
- R5: Operation code 2'b10 (insert) writes the low field-length bits of source A into the old destination value starting at bit start, wrapping past bit 63 as needed. Every bit outside the field keeps the old destination value.
- R6: Operation code 2'b11 (mask-merge) forms a mask of field-length ones rotated left by start. The result takes old-destination bits where the mask is 1 and source A bits where it is 0.
- R7: An operation accepted with valid and enable high produces its result and a one-cycle result-valid pulse on the next rising clock edge. Result-valid is low in every cycle that does not follow an accepted operation.
- R8: Valid with enable low raises the illegal flag for one cycle after the clock edge. Result-valid stays low and the result output is not changed.
- R9: A field with end = (start-1) mod 64 is 64 bits long. Extract then returns source A rotated right by start, insert returns source A rotated left by start, and mask-merge returns the old destination unchanged.
- R10: A synchronous active-high reset clears the result, result-valid and the illegal flag.
- R11: The result output holds its value in every cycle that does not follow an accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | Operation presented this cycle |
| opEnable | input | 1 | Operation enable; low with opValid is illegal |
| opSel | input | 2 | 00 zero-extract, 01 sign-extract, 10 insert, 11 mask-merge |
| fieldStart | input | 6 | Low bit index of the field |
| fieldEnd | input | 6 | High bit index of the field |
| srcA | input | 64 | Source operand |
| oldDst | input | 64 | Previous destination value |
| result | output | 64 | Registered result |
| resValid | output | 1 | Result valid, one cycle after acceptance |
| illegalFlag | output | 1 | Rejected operation, one cycle after the strobe |

## Verification
Two events can land on the same clock edge: the registration of a new result and a rejected operation right behind it, or two accepted operations issued back to back. The bench keeps valid high across consecutive cycles, alternating legal operations with a disabled one. In each following cycle it checks that the flags match that cycle's request and that a rejected slot leaves the previous result in place while the next legal one replaces it.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [1:0] {
    BF_EXTU  = 2'b00,
    BF_EXTS  = 2'b01,
    BF_INS   = 2'b10,
    BF_MERGE = 2'b11
  } bfOp_e;

  typedef struct packed {
    logic accept;
    logic illegal;
    logic extract;
    logic signExt;
    logic insert;
    logic merge;
  } bfStrobe_t;

endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic       opValid,
  input  logic       opEnable,
  input  logic [1:0] opSel,
  output bfStrobe_t  strobes
);

  always_comb begin
    strobes         = '0;
    strobes.accept  = opValid && opEnable;
    strobes.illegal = opValid && !opEnable;
    if (strobes.accept) begin
      unique case (bfOp_e'(opSel))
        BF_EXTU:  strobes.extract = 1'b1;
        BF_EXTS: begin
          strobes.extract = 1'b1;
          strobes.signExt = 1'b1;
        end
        BF_INS:   strobes.insert = 1'b1;
        BF_MERGE: strobes.merge  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int DataW = 64,
  localparam int IdxW = $clog2(DataW),
  localparam int LenW = IdxW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  bfStrobe_t        strobes,
  input  logic [DataW-1:0] srcA,
  input  logic [DataW-1:0] oldDst,
  input  logic [IdxW-1:0]  fieldStart,
  input  logic [IdxW-1:0]  fieldEnd,
  output logic [DataW-1:0] result,
  output logic             resValid,
  output logic             illegalFlag
);

  function automatic logic [DataW-1:0] rotLeft(input logic [DataW-1:0] v,
                                               input logic [IdxW-1:0] n);
    logic [2*DataW-1:0] twice;
    twice = {v, v} << n;
    return twice[2*DataW-1:DataW];
  endfunction

  logic             wraps;
  logic [LenW-1:0]  fieldLen;
  logic             fullWord;
  logic [DataW-1:0] lowOnes;
  logic [DataW-1:0] fieldMask;
  logic [IdxW-1:0]  rotAmt;
  logic [IdxW-1:0]  shiftAmt;
  logic [DataW-1:0] aligned;
  logic [DataW-1:0] extVal;
  logic [DataW-1:0] insVal;
  logic [DataW-1:0] mrgVal;
  logic [DataW-1:0] nextResult;

  always_comb begin
    wraps = fieldStart > fieldEnd;
    if (wraps)
      fieldLen = LenW'(DataW) - LenW'(fieldStart) + LenW'(fieldEnd) + LenW'(1);
    else
      fieldLen = LenW'(fieldEnd) - LenW'(fieldStart) + LenW'(1);
    fullWord  = fieldLen == LenW'(DataW);
    lowOnes   = fullWord ? {DataW{1'b1}} : ((DataW'(1) << fieldLen) - DataW'(1));
    fieldMask = rotLeft(lowOnes, fieldStart);
  end

  // extract: park the field's top bit at the MSB, then shift down
  always_comb begin
    rotAmt   = IdxW'(DataW - 1) - fieldEnd;
    shiftAmt = fieldStart + rotAmt;
    aligned  = rotLeft(srcA, rotAmt);
    if (strobes.signExt)
      extVal = DataW'($signed(aligned) >>> shiftAmt);
    else
      extVal = aligned >> shiftAmt;
  end

  always_comb begin
    insVal = (rotLeft(srcA, fieldStart) & fieldMask) | (oldDst & ~fieldMask);
    mrgVal = (oldDst & fieldMask) | (srcA & ~fieldMask);
    if (strobes.insert)      nextResult = insVal;
    else if (strobes.merge)  nextResult = mrgVal;
    else                     nextResult = extVal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      resValid    <= 1'b0;
      illegalFlag <= 1'b0;
    end else begin
      resValid    <= strobes.accept;
      illegalFlag <= strobes.illegal;
      if (strobes.accept) result <= nextResult;
    end
  end

  assert_accept_to_valid_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.accept |=> resValid);

  assert_idle_no_valid_R7: assert property (@(posedge clk) disable iff (rst)
    !strobes.accept |=> !resValid);

  assert_illegal_flag_R8: assert property (@(posedge clk) disable iff (rst)
    strobes.illegal |=> (illegalFlag && !resValid));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(resValid && illegalFlag));

  assert_hold_result_R11: assert property (@(posedge clk) disable iff (rst)
    !strobes.accept |=> $stable(result));

  assert_extu_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (strobes.extract && !strobes.signExt && !fullWord)
      |=> ((result >> $past(fieldLen)) == '0));

  assert_insert_outside_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.insert |=> (((result ^ $past(oldDst)) & ~$past(fieldMask)) == '0));

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int DataW = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       opValid,
  input  logic                       opEnable,
  input  logic [1:0]                 opSel,
  input  logic [$clog2(DataW)-1:0]   fieldStart,
  input  logic [$clog2(DataW)-1:0]   fieldEnd,
  input  logic [DataW-1:0]           srcA,
  input  logic [DataW-1:0]           oldDst,
  output logic [DataW-1:0]           result,
  output logic                       resValid,
  output logic                       illegalFlag
);

  bfStrobe_t strobes;

  bfu_ctrl uCtrl (
    .opValid  (opValid),
    .opEnable (opEnable),
    .opSel    (opSel),
    .strobes  (strobes)
  );

  bfu_datapath #(.DataW(DataW)) uPath (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .srcA        (srcA),
    .oldDst      (oldDst),
    .fieldStart  (fieldStart),
    .fieldEnd    (fieldEnd),
    .result      (result),
    .resValid    (resValid),
    .illegalFlag (illegalFlag)
  );

endmodule

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic        opEnable = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [5:0]  fieldStart = '0;
  logic [5:0]  fieldEnd = '0;
  logic [63:0] srcA = '0;
  logic [63:0] oldDst = '0;
  logic [63:0] result;
  logic        resValid;
  logic        illegalFlag;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  bitfield_unit uut (
    .clk(clk), .rst(rst), .opValid(opValid), .opEnable(opEnable), .opSel(opSel),
    .fieldStart(fieldStart), .fieldEnd(fieldEnd), .srcA(srcA), .oldDst(oldDst),
    .result(result), .resValid(resValid), .illegalFlag(illegalFlag)
  );

  // stimulus: {op, start, end, srcA, oldDst}
  localparam logic [141:0] VECS [12] = '{
    {2'd0, 6'd0,  6'd7,  64'h0123_4567_89AB_CDEF, 64'h0},
    {2'd1, 6'd0,  6'd7,  64'h0123_4567_89AB_CDEF, 64'h0},
    {2'd1, 6'd0,  6'd15, 64'h0000_0000_0000_7FFF, 64'h0},
    {2'd1, 6'd4,  6'd11, 64'hFFFF_FFFF_FFFF_F80F, 64'h0},
    {2'd0, 6'd60, 6'd3,  64'hA000_0000_0000_0005, 64'h0},
    {2'd1, 6'd60, 6'd3,  64'hA000_0000_0000_000C, 64'h0},
    {2'd2, 6'd8,  6'd15, 64'h0000_0000_0000_00AB, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'd2, 6'd62, 6'd1,  64'h0000_0000_0000_000F, 64'h0},
    {2'd3, 6'd0,  6'd31, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222},
    {2'd3, 6'd56, 6'd7,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    {2'd0, 6'd0,  6'd63, 64'hDEAD_BEEF_CAFE_F00D, 64'h0},
    {2'd2, 6'd33, 6'd33, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0}
  };

  function automatic logic [63:0] refModel(input logic [1:0] op, input int s, input int e,
                                           input logic [63:0] a, input logic [63:0] d);
    int len;
    logic [63:0] r;
    logic [63:0] m;
    len = (s <= e) ? (e - s + 1) : ((64 - s) + (e + 1));
    m = '0;
    for (int i = 0; i < len; i++) m[(s + i) % 64] = 1'b1;
    r = '0;
    case (op)
      2'd0, 2'd1: begin
        r = (op == 2'd1) ? {64{a[e]}} : 64'h0;
        for (int i = 0; i < len; i++) r[i] = a[(s + i) % 64];
      end
      2'd2: begin
        r = d;
        for (int i = 0; i < len; i++) r[(s + i) % 64] = a[i];
      end
      default: for (int j = 0; j < 64; j++) r[j] = m[j] ? d[j] : a[j];
    endcase
    return r;
  endfunction

  function automatic string opReq(input logic [1:0] op);
    case (op)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string fieldReq(input int s, input int e);
    if (((e + 1) % 64) == s) return "R9";
    if (s > e) return "R2";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input int s, input int e,
                       input logic [63:0] a, input logic [63:0] d);
    logic [63:0] exp;
    exp = refModel(op, s, e, a, d);
    @(negedge clk);
    opValid = 1'b1; opEnable = 1'b1; opSel = op;
    fieldStart = 6'(s); fieldEnd = 6'(e); srcA = a; oldDst = d;
    @(negedge clk);
    opValid = 1'b0;
    check({opReq(op), " ", fieldReq(s, e), " result"}, result, exp);
    check("R7 resValid", {63'd0, resValid}, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] held;
    logic [63:0] ra;
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 result", result, 64'h0);
    check("R10 flags", {62'd0, resValid, illegalFlag}, 64'd0);
    rst = 1'b0;

    for (int k = 0; k < 12; k++)
      runOp(VECS[k][141:140], int'(VECS[k][139:134]), int'(VECS[k][133:128]),
            VECS[k][127:64], VECS[k][63:0]);

    // edge start/end combinations with random operands
    for (int p = 0; p < 11; p++) begin
      int s;
      int e;
      case (p)
        0: begin s = 0;  e = 7;  end
        1: begin s = 0;  e = 15; end
        2: begin s = 0;  e = 31; end
        3: begin s = 0;  e = 63; end
        4: begin s = 9;  e = 9;  end
        5: begin s = 63; e = 63; end
        6: begin s = 60; e = 3;  end
        7: begin s = 63; e = 0;  end
        8: begin s = 1;  e = 0;  end
        9: begin s = 32; e = 31; end
        default: begin s = 40; e = 20; end
      endcase
      for (int op = 0; op < 4; op++)
        for (int n = 0; n < 3; n++)
          runOp(2'(op), s, e, {$urandom, $urandom}, {$urandom, $urandom});
    end

    // R9: full-length field written out directly
    ra = 64'h0123_4567_89AB_CDEF;
    rd = 64'h5555_AAAA_5555_AAAA;
    runOp(2'd0, 5, 4, ra, rd);
    check("R9 extract rotate", result, (ra >> 5) | (ra << 59));
    runOp(2'd2, 10, 9, ra, rd);
    check("R9 insert rotate", result, (ra << 10) | (ra >> 54));
    runOp(2'd3, 10, 9, ra, rd);
    check("R9 merge keeps old", result, rd);

    // R11: idle cycles hold result, no valid
    held = result;
    @(negedge clk);
    @(negedge clk);
    check("R11 hold", result, held);
    check("R7 idle valid", {63'd0, resValid}, 64'd0);

    // R8: disabled operation
    @(negedge clk);
    opValid = 1'b1; opEnable = 1'b0; opSel = 2'd2;
    fieldStart = 6'd0; fieldEnd = 6'd63; srcA = 64'hFFFF; oldDst = 64'h1;
    @(negedge clk);
    opValid = 1'b0;
    check("R8 illegal set", {63'd0, illegalFlag}, 64'd1);
    check("R8 no valid", {63'd0, resValid}, 64'd0);
    check("R8 result unchanged", result, held);
    @(negedge clk);
    check("R8 illegal clears", {63'd0, illegalFlag}, 64'd0);

    // back-to-back: legal, illegal, legal
    ra = 64'hF0F0_1234_5678_9ABC;
    @(negedge clk);
    opValid = 1'b1; opEnable = 1'b1; opSel = 2'd0;
    fieldStart = 6'd8; fieldEnd = 6'd23; srcA = ra; oldDst = '0;
    @(negedge clk);
    check("R3 b2b first", result, 64'h0000_0000_0000_789A);
    opEnable = 1'b0;
    @(negedge clk);
    check("R8 b2b illegal", {62'd0, resValid, illegalFlag}, 64'd1);
    check("R8 b2b result held", result, 64'h0000_0000_0000_789A);
    opEnable = 1'b1; opSel = 2'd1; fieldStart = 6'd60; fieldEnd = 6'd63;
    @(negedge clk);
    opValid = 1'b0;
    check("R4 b2b second", result, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R7 b2b valid", {62'd0, resValid, illegalFlag}, 64'd2);

    // R10: reset while a result is pending
    @(negedge clk);
    opValid = 1'b1; opEnable = 1'b1; opSel = 2'd3;
    rst = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    check("R10 reset result", result, 64'h0);
    check("R10 reset flags", {62'd0, resValid, illegalFlag}, 64'd0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule